// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date as a set of packed BCD counters. A one-cycle enable pulse, which arrives at 100 Hz from a divider outside the block, advances the chain. The chain runs from hundredths of a second through seconds, minutes and hours to the day of the month, the month and a two-digit year. Two more counters advance once per day beside the calendar: a weekday number and an ordinal day within the year.

An input pin selects whether hours count in 24-hour form or in 12-hour form with a PM flag. February gets a 29th day whenever the year is a multiple of four. Software sets any counter through a single-cycle write port that selects one field by code. Every counter is visible at its own output bus. The block does not convert the hour value when the mode pin changes, so software reloads the hour after it switches modes.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the counters read hundredths 00, seconds 00, minutes 00, hour 00, PM flag 0, day of month 01, month 01, year 00, weekday 1 and day of year 001.
- R2: Hundredths count 00 to 99 in BCD, by one for each tick cycle. Seconds and minutes count 00 to 59. When a counter wraps to 00, the next counter up advances in the same cycle.
- R3: With hr24_mode = 1, the hour counts 00 to 23. The step from 23 to 00 ends the day.
- R4: With hr24_mode = 0, the hour runs 12, 01 … 11, 12. The PM flag inverts on each step from 11 to 12. The day ends only on the step where the flag goes from 1 to 0.
- R5: At the end of a day, the day of month wraps to 01 after its last day and the month advances. The last day is 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 for all other months. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: A year whose BCD value is a multiple of four, 00 included, is a leap year. In a leap year, February ends after day 29.
- R7: The weekday counts 1 to 7, advances once at each end of day and wraps from 7 to 1, whatever the month.
- R8: The day of year (12-bit BCD) counts from 001. It wraps to 001 after 365, or after 366 in a leap year.
- R9: When wr_en is high, the field picked by wr_sel takes its value from wr_data on the next edge. The codes are 0 hundredths, 1 seconds, 2 minutes, 3 hour, 4 day of month, 5 month, 6 year, 7 weekday and 8 day of year. Two-digit fields take wr_data[7:0]. The hour write also loads the PM flag from wr_data[8]. The weekday takes wr_data[3:0] and the day of year takes wr_data[11:0].
- R10: A write cycle discards any tick in the same cycle. The fields that are not addressed hold their values.
- R11: With tick_100hz and wr_en both low, every counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_100hz | input | 1 | One-cycle advance enable, 100 Hz |
| hr24_mode | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour counting |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Field code for the write |
| wr_data | input | 12 | BCD write value |
| hund_o | output | 8 | Hundredths of a second |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour |
| pm_o | output | 1 | PM flag |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| wday_o | output | 4 | Weekday, 1 to 7 |
| yday_o | output | 12 | Day of year, 001 to 366 |

## Verification
At one tick per cycle, the calendar fields would need millions of cycles to reach a month or year boundary. That makes the end of a leap-year February and the end of a 99th year hard to reach from the ports. The stimulus uses the write port to place the counters one tick away from such a boundary, then ticks once, so that every carry fires in a single cycle. Random loads of the year, month and day, mixed with ticks and with writes that land in tick cycles, drive the same carries across many month and leap-year combinations. A bench model checks every result.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BCD2_W  = 8;
    localparam int BCD3_W  = 12;
    localparam int WDAY_W  = 4;
    localparam int SEL_W   = 4;

    typedef enum logic [SEL_W-1:0] {
        FLD_HUND  = 4'd0,
        FLD_SEC   = 4'd1,
        FLD_MIN   = 4'd2,
        FLD_HOUR  = 4'd3,
        FLD_MDAY  = 4'd4,
        FLD_MONTH = 4'd5,
        FLD_YEAR  = 4'd6,
        FLD_WDAY  = 4'd7,
        FLD_YDAY  = 4'd8
    } rtc_field_e;

    typedef struct packed {
        logic [BCD2_W-1:0] hund;
        logic [BCD2_W-1:0] sec;
        logic [BCD2_W-1:0] min;
        logic [BCD2_W-1:0] mday;
        logic [BCD2_W-1:0] month;
        logic [BCD2_W-1:0] year;
        logic [WDAY_W-1:0] wday;
        logic [BCD3_W-1:0] yday;
    } cal_state_t;

    typedef struct packed {
        logic [BCD2_W-1:0] hour;
        logic              pm;
    } hour_state_t;

    // Two-digit BCD increment (no wrap; callers handle limits).
    function automatic logic [BCD2_W-1:0] bcd2_inc(input logic [BCD2_W-1:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Three-digit BCD increment.
    function automatic logic [BCD3_W-1:0] bcd3_inc(input logic [BCD3_W-1:0] v);
        logic [BCD3_W-1:0] r;
        r = v;
        if (v[3:0] < 4'd9) begin
            r[3:0] = v[3:0] + 4'd1;
        end else begin
            r[3:0] = 4'd0;
            if (v[7:4] < 4'd9) begin
                r[7:4] = v[7:4] + 4'd1;
            end else begin
                r[7:4]  = 4'd0;
                r[11:8] = v[11:8] + 4'd1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_leap_detect.sv
module rtc_leap_detect
    import rtc_pkg::*;
(
    input  logic [BCD2_W-1:0] year_bcd,
    output logic              leap
);
    // A decimal number is a multiple of four when: tens even and ones in {0,4,8},
    // or tens odd and ones in {2,6}.
    logic tens_odd;
    logic [3:0] ones;

    always_comb begin
        tens_odd = year_bcd[4];
        ones     = year_bcd[3:0];
        if (!tens_odd) leap = (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
        else           leap = (ones == 4'd2) || (ones == 4'd6);
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [BCD2_W-1:0] month_bcd,
    input  logic              leap,
    output logic [BCD2_W-1:0] last_day
);
    always_comb begin
        unique case (month_bcd)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              mode24,
    input  logic              load,
    input  logic [BCD2_W-1:0] load_hour,
    input  logic              load_pm,
    output logic [BCD2_W-1:0] hour,
    output logic              pm,
    output logic              day_end
);
    hour_state_t hs_d, hs_q;

    always_comb begin
        hs_d    = hs_q;
        day_end = 1'b0;
        if (load) begin
            hs_d.hour = load_hour;
            hs_d.pm   = load_pm;
        end else if (step) begin
            if (mode24) begin
                if (hs_q.hour >= 8'h23) begin
                    hs_d.hour = 8'h00;
                    day_end   = 1'b1;
                end else begin
                    hs_d.hour = bcd2_inc(hs_q.hour);
                end
            end else begin
                if (hs_q.hour == 8'h11) begin
                    hs_d.hour = 8'h12;
                    hs_d.pm   = ~hs_q.pm;
                    day_end   = hs_q.pm;
                end else if (hs_q.hour >= 8'h12) begin
                    hs_d.hour = 8'h01;
                end else begin
                    hs_d.hour = bcd2_inc(hs_q.hour);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q.hour <= 8'h00;
            hs_q.pm   <= 1'b0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign hour = hs_q.hour;
    assign pm   = hs_q.pm;

    // PM flag may only change on a load or when the hour lands on 12.
    assert_pm_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (hs_d.pm != hs_q.pm)) |=> (hs_q.hour == 8'h12));

    // Without a step or load the hour and flag hold.
    assert_hour_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(hs_q.hour) && $stable(hs_q.pm)));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int WDAY_LAST = 7,
    parameter int DATA_W    = 12,
    parameter int SELW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              hr24_mode,
    input  logic              wr_en,
    input  logic [SELW-1:0]   wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [7:0]        hund_o,
    output logic [7:0]        sec_o,
    output logic [7:0]        min_o,
    output logic [7:0]        hour_o,
    output logic              pm_o,
    output logic [7:0]        mday_o,
    output logic [7:0]        month_o,
    output logic [7:0]        year_o,
    output logic [3:0]        wday_o,
    output logic [11:0]       yday_o
);
    localparam logic [WDAY_W-1:0] WDAY_MAX = WDAY_W'(WDAY_LAST);

    cal_state_t        st_d, st_q;
    rtc_field_e        fld;
    logic              adv, c_sec, c_min, c_hour, day_end;
    logic              leap, month_end, hour_load;
    logic [BCD2_W-1:0] last_day;
    logic [BCD3_W-1:0] yday_last;
    logic [BCD2_W-1:0] hour_q;
    logic              pm_q;

    assign fld       = rtc_field_e'(wr_sel);
    assign adv       = tick_100hz && !wr_en;
    assign c_sec     = adv    && (st_q.hund >= 8'h99);
    assign c_min     = c_sec  && (st_q.sec  >= 8'h59);
    assign c_hour    = c_min  && (st_q.min  >= 8'h59);
    assign hour_load = wr_en && (fld == FLD_HOUR);

    rtc_leap_detect u_leap (
        .year_bcd (st_q.year),
        .leap     (leap)
    );

    rtc_month_len u_mlen (
        .month_bcd (st_q.month),
        .leap      (leap),
        .last_day  (last_day)
    );

    rtc_hour_ctr u_hour (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (c_hour),
        .mode24    (hr24_mode),
        .load      (hour_load),
        .load_hour (wr_data[7:0]),
        .load_pm   (wr_data[8]),
        .hour      (hour_q),
        .pm        (pm_q),
        .day_end   (day_end)
    );

    assign month_end = st_q.mday >= last_day;
    assign yday_last = leap ? 12'h366 : 12'h365;

    always_comb begin
        st_d = st_q;
        if (adv)
            st_d.hund = c_sec ? 8'h00 : bcd2_inc(st_q.hund);
        if (c_sec)
            st_d.sec = c_min ? 8'h00 : bcd2_inc(st_q.sec);
        if (c_min)
            st_d.min = c_hour ? 8'h00 : bcd2_inc(st_q.min);
        if (day_end) begin
            st_d.wday = (st_q.wday >= WDAY_MAX) ? WDAY_W'(1) : st_q.wday + WDAY_W'(1);
            st_d.yday = (st_q.yday >= yday_last) ? 12'h001 : bcd3_inc(st_q.yday);
            if (month_end) begin
                st_d.mday = 8'h01;
                if (st_q.month >= 8'h12) begin
                    st_d.month = 8'h01;
                    st_d.year  = (st_q.year >= 8'h99) ? 8'h00 : bcd2_inc(st_q.year);
                end else begin
                    st_d.month = bcd2_inc(st_q.month);
                end
            end else begin
                st_d.mday = bcd2_inc(st_q.mday);
            end
        end
        if (wr_en) begin
            case (fld)
                FLD_HUND:  st_d.hund  = wr_data[7:0];
                FLD_SEC:   st_d.sec   = wr_data[7:0];
                FLD_MIN:   st_d.min   = wr_data[7:0];
                FLD_MDAY:  st_d.mday  = wr_data[7:0];
                FLD_MONTH: st_d.month = wr_data[7:0];
                FLD_YEAR:  st_d.year  = wr_data[7:0];
                FLD_WDAY:  st_d.wday  = wr_data[WDAY_W-1:0];
                FLD_YDAY:  st_d.yday  = wr_data[BCD3_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hund  <= 8'h00;
            st_q.sec   <= 8'h00;
            st_q.min   <= 8'h00;
            st_q.mday  <= 8'h01;
            st_q.month <= 8'h01;
            st_q.year  <= 8'h00;
            st_q.wday  <= WDAY_W'(1);
            st_q.yday  <= 12'h001;
        end else begin
            st_q <= st_d;
        end
    end

    assign hund_o  = st_q.hund;
    assign sec_o   = st_q.sec;
    assign min_o   = st_q.min;
    assign hour_o  = hour_q;
    assign pm_o    = pm_q;
    assign mday_o  = st_q.mday;
    assign month_o = st_q.month;
    assign year_o  = st_q.year;
    assign wday_o  = st_q.wday;
    assign yday_o  = st_q.yday;

    // Seconds move only on a hundredths wrap or a write.
    assert_sec_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(tick_100hz && st_q.hund == 8'h99)) |=> $stable(st_q.sec));

    // 23:59:59.99 plus a tick in 24-hour mode gives hour 00 and a new date.
    assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hr24_mode && hour_q == 8'h23 && st_q.min == 8'h59 &&
         st_q.sec == 8'h59 && st_q.hund == 8'h99)
        |=> (hour_q == 8'h00 && st_q.mday != $past(st_q.mday) &&
             st_q.wday != $past(st_q.wday)));

    // Date-side counters hold unless the hour chain ends a day or a write lands.
    assert_date_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !day_end) |=> ($stable(st_q.mday) && $stable(st_q.wday) &&
                                   $stable(st_q.yday) && $stable(st_q.month)));

    // A seconds write lands on the next edge and stops that cycle's tick.
    assert_write_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == FLD_SEC) |=> (st_q.sec == $past(wr_data[7:0]) &&
                                        $stable(st_q.hund)));

    // No tick, no write: the fast counters hold.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_100hz && !wr_en) |=> ($stable(st_q.hund) && $stable(st_q.min)));
endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_100hz = 1'b0;
    logic        hr24_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = 4'd0;
    logic [11:0] wr_data = 12'd0;
    logic [7:0]  hund_o, sec_o, min_o, hour_o, mday_o, month_o, year_o;
    logic        pm_o;
    logic [3:0]  wday_o;
    logic [11:0] yday_o;

    int checks = 0;
    int failures = 0;

    // reference model, plain integers
    int m_h, m_s, m_mi, m_hr, m_pm, m_md, m_mo, m_yr, m_wd, m_yd;

    always #10 clk = ~clk;

    rtc_calendar u0 (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .hr24_mode(hr24_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .pm_o(pm_o),
        .mday_o(mday_o), .month_o(month_o), .year_o(year_o), .wday_o(wday_o),
        .yday_o(yday_o)
    );

    function automatic logic [11:0] to_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(input logic [11:0] b);
        return int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2", "hund", int'(hund_o), int'(to_bcd(m_h)));
        chk("R2", "sec",  int'(sec_o),  int'(to_bcd(m_s)));
        chk("R2", "min",  int'(min_o),  int'(to_bcd(m_mi)));
        chk(hr24_mode ? "R3" : "R4", "hour", int'(hour_o), int'(to_bcd(m_hr)));
        chk("R4", "pm",   int'(pm_o),   m_pm);
        chk("R5", "mday", int'(mday_o), int'(to_bcd(m_md)));
        chk("R5", "month", int'(month_o), int'(to_bcd(m_mo)));
        chk("R5", "year", int'(year_o), int'(to_bcd(m_yr)));
        chk("R7", "wday", int'(wday_o), m_wd);
        chk("R8", "yday", int'(yday_o), int'(to_bcd(m_yd)));
    endtask

    task automatic model_day();
        int lim;
        lim = (m_yr % 4 == 0) ? 366 : 365;
        m_wd = (m_wd >= 7) ? 1 : m_wd + 1;
        m_yd = (m_yd >= lim) ? 1 : m_yd + 1;
        if (m_md >= days_in(m_mo, m_yr)) begin
            m_md = 1;
            if (m_mo >= 12) begin
                m_mo = 1;
                m_yr = (m_yr + 1) % 100;
            end else m_mo++;
        end else m_md++;
    endtask

    task automatic model_tick();
        m_h++;
        if (m_h < 100) return;
        m_h = 0; m_s++;
        if (m_s < 60) return;
        m_s = 0; m_mi++;
        if (m_mi < 60) return;
        m_mi = 0;
        if (hr24_mode) begin
            m_hr++;
            if (m_hr >= 24) begin m_hr = 0; model_day(); end
        end else if (m_hr == 11) begin
            m_hr = 12;
            m_pm = 1 - m_pm;
            if (m_pm == 0) model_day();
        end else if (m_hr == 12) m_hr = 1;
        else m_hr++;
    endtask

    task automatic model_write(input int sel, input logic [11:0] d);
        case (sel)
            0: m_h  = from_bcd({4'd0, d[7:0]});
            1: m_s  = from_bcd({4'd0, d[7:0]});
            2: m_mi = from_bcd({4'd0, d[7:0]});
            3: begin m_hr = from_bcd({4'd0, d[7:0]}); m_pm = int'(d[8]); end
            4: m_md = from_bcd({4'd0, d[7:0]});
            5: m_mo = from_bcd({4'd0, d[7:0]});
            6: m_yr = from_bcd({4'd0, d[7:0]});
            7: m_wd = int'(d[3:0]);
            8: m_yd = from_bcd(d);
            default: ;
        endcase
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge
    task automatic cyc(input logic tk, input logic we, input int sel, input logic [11:0] d);
        tick_100hz = tk; wr_en = we; wr_sel = 4'(sel); wr_data = d;
        @(posedge clk);
        if (we) model_write(sel, d);
        else if (tk) model_tick();
        @(negedge clk);
        tick_100hz = 1'b0; wr_en = 1'b0;
        check_all();
    endtask

    task automatic wr(input int sel, input int val);
        cyc(1'b0, 1'b1, sel, to_bcd(val));
    endtask

    task automatic set_all(input int h, input int s, input int mi, input int hr, input int pm,
                           input int md, input int mo, input int yr, input int wd, input int yd);
        wr(0, h); wr(1, s); wr(2, mi);
        cyc(1'b0, 1'b1, 3, to_bcd(hr) | (pm != 0 ? 12'h100 : 12'h000));
        wr(4, md); wr(5, mo); wr(6, yr); wr(7, wd); wr(8, yd);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        int r, sel, v, yd0;
        seed = $urandom(32'h5eed_1234);
        m_h = 0; m_s = 0; m_mi = 0; m_hr = 0; m_pm = 0;
        m_md = 1; m_mo = 1; m_yr = 0; m_wd = 1; m_yd = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1", "hund", int'(hund_o), 0);
        chk("R1", "hour", int'(hour_o), 0);
        chk("R1", "pm",   int'(pm_o), 0);
        chk("R1", "mday", int'(mday_o), 'h01);
        chk("R1", "month", int'(month_o), 'h01);
        chk("R1", "wday", int'(wday_o), 1);
        chk("R1", "yday", int'(yday_o), 'h001);

        // R11 idle holds
        repeat (5) cyc(1'b0, 1'b0, 0, 12'h0);
        chk("R11", "hund idle", int'(hund_o), 0);

        // R2 basic counting
        repeat (150) cyc(1'b1, 1'b0, 0, 12'h0);
        chk("R2", "sec after 150 ticks", int'(sec_o), 'h01);

        // R3/R5/R7/R8 end of year 99 in 24-hour mode
        hr24_mode = 1'b1;
        set_all(99, 59, 59, 23, 0, 31, 12, 99, 7, 365);
        cyc(1'b1, 1'b0, 0, 12'h0);
        chk("R5", "year wrap", int'(year_o), 'h00);
        chk("R7", "wday wrap", int'(wday_o), 1);
        chk("R8", "yday wrap", int'(yday_o), 'h001);

        // R6 leap February in year 24
        set_all(99, 59, 59, 23, 0, 28, 2, 24, 3, 59);
        cyc(1'b1, 1'b0, 0, 12'h0);
        chk("R6", "leap feb 29", int'(mday_o), 'h29);
        wr(0, 99); wr(1, 59); wr(2, 59); wr(3, 23);
        cyc(1'b1, 1'b0, 0, 12'h0);
        chk("R6", "leap mar 1", int'(month_o), 'h03);
        // non-leap 23
        set_all(99, 59, 59, 23, 0, 28, 2, 23, 3, 59);
        cyc(1'b1, 1'b0, 0, 12'h0);
        chk("R6", "nonleap mar 1", int'(mday_o), 'h01);
        // R8 yday 366 in leap year 00
        set_all(99, 59, 59, 23, 0, 30, 12, 0, 2, 365);
        cyc(1'b1, 1'b0, 0, 12'h0);
        chk("R8", "yday 366", int'(yday_o), 'h366);

        // R4 12-hour mode: 11 AM -> 12 PM keeps date; 11 PM -> 12 AM ends day
        hr24_mode = 1'b0;
        set_all(99, 59, 59, 11, 0, 10, 5, 30, 4, 130);
        cyc(1'b1, 1'b0, 0, 12'h0);
        chk("R4", "noon pm", int'(pm_o), 1);
        chk("R4", "noon mday", int'(mday_o), 'h10);
        wr(0, 99); wr(1, 59); wr(2, 59); cyc(1'b0, 1'b1, 3, 12'h111);
        cyc(1'b1, 1'b0, 0, 12'h0);
        chk("R4", "midnight pm", int'(pm_o), 0);
        chk("R4", "midnight mday", int'(mday_o), 'h11);
        repeat (3) begin
            wr(0, 99); wr(1, 59); wr(2, 59);
            cyc(1'b1, 1'b0, 0, 12'h0);
        end
        chk("R4", "12 to 01", int'(hour_o), 'h03);

        // R9/R10 write with tick in the same cycle
        wr(0, 42);
        cyc(1'b1, 1'b1, 1, to_bcd(17));
        chk("R9", "sec written", int'(sec_o), 'h17);
        chk("R10", "hund held", int'(hund_o), 'h42);
        cyc(1'b1, 1'b1, 8, to_bcd(200));
        chk("R9", "yday written", int'(yday_o), 'h200);
        chk("R10", "hund held 2", int'(hund_o), 'h42);

        // random phases in both modes
        for (int ph = 0; ph < 2; ph++) begin
            hr24_mode = (ph == 0);
            v = hr24_mode ? 23 : 11;
            cyc(1'b0, 1'b1, 3, to_bcd(v) | 12'h100);
            for (int i = 0; i < 700; i++) begin
                r = $urandom % 10;
                if (r < 2) begin
                    sel = $urandom % 9;
                    case (sel)
                        0: v = $urandom % 100;
                        1, 2: v = $urandom % 60;
                        3: v = hr24_mode ? ($urandom % 24) : (1 + $urandom % 12);
                        4: v = 1 + $urandom % 31;
                        5: v = 1 + $urandom % 12;
                        6: v = $urandom % 100;
                        7: v = 1 + $urandom % 7;
                        default: v = 1 + $urandom % 366;
                    endcase
                    if (sel == 3) cyc(1'($urandom % 2), 1'b1, 3, to_bcd(v) | 12'(($urandom % 2) << 8));
                    else cyc(1'($urandom % 2), 1'b1, sel, to_bcd(v));
                end else if (r < 5) begin
                    v = 1 + $urandom % 12;
                    wr(5, v);
                    wr(4, days_in(v, m_yr) - ($urandom % 2));
                    yd0 = 364 + $urandom % 3;
                    wr(8, yd0);
                    wr(0, 99); wr(1, 59); wr(2, 59);
                    if (hr24_mode) wr(3, 23);
                    else cyc(1'b0, 1'b1, 3, 12'h111);
                    cyc(1'b1, 1'b0, 0, 12'h0);
                end else begin
                    cyc(1'($urandom % 5 != 0), 1'b0, 0, 12'h0);
                end
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule